// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

This unit is the shifter and flag-bit slice of a small microcontroller datapath. Each cycle it takes one operand byte, an operation code, a bit index and the current 8-bit status word. One clock edge later it presents three things: the result byte, a write-enable for the destination register, and the next status word. It performs these operations:

- logical shifts left and right;
- rotates through the carry flag, left and right;
- arithmetic shift right;
- nibble exchange;
- copying an operand bit into the transfer flag, and writing the transfer flag into an operand bit;
- setting or clearing a single status flag.

Every operation changes only its own set of flags. The status word uses this bit order, and the flag set/clear operations rely on it: bit 7 I (interrupt enable), bit 6 T (transfer), bit 5 H (half carry), bit 4 S (sign), bit 3 V (overflow), bit 2 N (negative), bit 1 Z (zero), bit 0 C (carry).

Operation codes on `op_sel`:

| Code | Operation |
|------|-----------|
| 0 | no-op |
| 1 | shift left |
| 2 | logical shift right |
| 3 | rotate left |
| 4 | rotate right |
| 5 | arithmetic shift right |
| 6 | nibble swap |
| 7 | bit to T |
| 8 | T to bit |
| 9 | flag set |
| 10 | flag clear |
| 11 to 15 | treated as no-op |

Top module: `shbit_unit`

## Requirements
- R1: Shift left (code 1) outputs the operand moved up one place with bit 0 = 0. C becomes old bit 7 and H becomes old bit 3.
- R2: Logical shift right (code 2) outputs the operand moved down one place with bit 7 = 0. C becomes old bit 0. H keeps its input value.
- R3: Rotate left (code 3) moves old C into bit 0, old bit 7 into C, and old bit 3 into H. Rotate right (code 4) moves old C into bit 7 and old bit 0 into C, and keeps H.
- R4: Arithmetic shift right (code 5) keeps bit 7, moves bits 7..1 down one place, sets C to old bit 0, and keeps H.
- R5: After any shift or rotate (codes 1-5), Z = (result == 0), N = result bit 7, V = N xor C, and S = N xor V, all taken from the new values. I and T keep their input values.
- R6: Nibble swap (code 6) exchanges bits 7..4 with bits 3..0. The status word passes through unchanged.
- R7: Bit to T (code 7) copies operand bit `bit_idx` into T (status bit 6). No other status bit changes.
- R8: T to bit (code 8) outputs the operand with bit `bit_idx` replaced by T. The status word is unchanged.
- R9: Flag set (code 9) and flag clear (code 10) force status bit `bit_idx` to 1 or 0 respectively. All other status bits pass through unchanged.
- R10: `res_we` is 1 for codes 1-6 and 8, and 0 for codes 0, 7, 9, 10 and 11-15. On the no-op codes the result equals the operand and the status word is unchanged.
- R11: Outputs are registered, so each operation appears exactly one clock after it is presented. While `rst_n` is low, `result`, `res_we` and `sreg_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| bit_idx | input | 3 | Operand bit or status bit index |
| operand | input | 8 | Operand byte |
| sreg_in | input | 8 | Current status word |
| result | output | 8 | Result byte |
| res_we | output | 1 | Destination write enable |
| sreg_out | output | 8 | Next status word |

## Verification
The assertions compare each registered output with the inputs sampled one edge earlier. They therefore assume that `op_sel`, `operand`, `sreg_in` and `bit_idx` are stable around every rising edge, and that the operation code is a known 4-bit value. The stimulus changes inputs only on falling edges. It draws codes from the full 0-15 range, so unused codes are exercised too. Random operands and status words are mixed with directed all-zero, all-ones, boundary-bit and each-index cases.

// File: rtl/shbit_pkg.sv
package shbit_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LSL  = 4'd1,
    OP_LSR  = 4'd2,
    OP_ROL  = 4'd3,
    OP_ROR  = 4'd4,
    OP_ASR  = 4'd5,
    OP_SWAP = 4'd6,
    OP_BST  = 4'd7,
    OP_BLD  = 4'd8,
    OP_FSET = 4'd9,
    OP_FCLR = 4'd10
  } shop_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;
  localparam int SREG_W = 8;
endpackage

// File: rtl/shbit_shift_core.sv
module shbit_shift_core
  import shbit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out,
  output logic         h_touch,
  output logic         sh_act,
  output logic         sw_act
);
  localparam int HALF = W / 2;
  localparam int HB   = 3;

  function automatic logic [W-1:0] f_left(input logic [W-1:0] v, input logic fill);
    return {v[W-2:0], fill};
  endfunction

  function automatic logic [W-1:0] f_right(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] f_swap(input logic [W-1:0] v);
    return {v[HALF-1:0], v[W-1:HALF]};
  endfunction

  always_comb begin
    res     = a;
    c_out   = c_in;
    h_out   = 1'b0;
    h_touch = 1'b0;
    sh_act  = 1'b0;
    sw_act  = 1'b0;
    case (op)
      OP_LSL: begin
        res = f_left(a, 1'b0); c_out = a[W-1];
        h_out = a[HB]; h_touch = 1'b1; sh_act = 1'b1;
      end
      OP_ROL: begin
        res = f_left(a, c_in); c_out = a[W-1];
        h_out = a[HB]; h_touch = 1'b1; sh_act = 1'b1;
      end
      OP_LSR: begin
        res = f_right(a, 1'b0); c_out = a[0]; sh_act = 1'b1;
      end
      OP_ROR: begin
        res = f_right(a, c_in); c_out = a[0]; sh_act = 1'b1;
      end
      OP_ASR: begin
        res = f_right(a, a[W-1]); c_out = a[0]; sh_act = 1'b1;
      end
      OP_SWAP: begin
        res = f_swap(a); sw_act = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shbit_flag_update.sv
module shbit_flag_update
  import shbit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SREG_W-1:0] sreg_in,
  input  logic [W-1:0]      res,
  input  logic              c_new,
  input  logic              h_new,
  input  logic              h_touch,
  output logic [SREG_W-1:0] sreg_new
);
  logic n_new, v_new, z_new;

  always_comb begin
    n_new = res[W-1];
    z_new = (res == '0);
    v_new = n_new ^ c_new;
    sreg_new       = sreg_in;
    sreg_new[FL_C] = c_new;
    sreg_new[FL_Z] = z_new;
    sreg_new[FL_N] = n_new;
    sreg_new[FL_V] = v_new;
    sreg_new[FL_S] = n_new ^ v_new;
    if (h_touch) sreg_new[FL_H] = h_new;
  end
endmodule

// File: rtl/shbit_bit_core.sv
module shbit_bit_core
  import shbit_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      a,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SREG_W-1:0] sreg_in,
  output logic [W-1:0]      res,
  output logic [SREG_W-1:0] sreg_new,
  output logic              wr,
  output logic              act
);
  always_comb begin
    res      = a;
    sreg_new = sreg_in;
    wr       = 1'b0;
    act      = 1'b1;
    case (op)
      OP_BST:  sreg_new[FL_T] = a[idx];
      OP_BLD:  begin res[idx] = sreg_in[FL_T]; wr = 1'b1; end
      OP_FSET: sreg_new[idx[2:0]] = 1'b1;
      OP_FCLR: sreg_new[idx[2:0]] = 1'b0;
      default: act = 1'b0;
    endcase
  end
endmodule

// File: rtl/shbit_unit.sv
module shbit_unit
  import shbit_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_sel,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [W-1:0]      operand,
  input  logic [SREG_W-1:0] sreg_in,
  output logic [W-1:0]      result,
  output logic              res_we,
  output logic [SREG_W-1:0] sreg_out
);
  logic [W-1:0]      sh_res, bt_res, nx_res;
  logic              sh_c, sh_h, sh_htouch, sh_act, sw_act;
  logic              bt_wr, bt_act, nx_we;
  logic [SREG_W-1:0] sh_sreg, bt_sreg, nx_sreg;

  shbit_shift_core #(.W(W)) u_shift (
    .op(op_sel), .a(operand), .c_in(sreg_in[FL_C]),
    .res(sh_res), .c_out(sh_c), .h_out(sh_h), .h_touch(sh_htouch),
    .sh_act(sh_act), .sw_act(sw_act)
  );

  shbit_flag_update #(.W(W)) u_flags (
    .sreg_in(sreg_in), .res(sh_res), .c_new(sh_c), .h_new(sh_h),
    .h_touch(sh_htouch), .sreg_new(sh_sreg)
  );

  shbit_bit_core #(.W(W)) u_bits (
    .op(op_sel), .a(operand), .idx(bit_idx), .sreg_in(sreg_in),
    .res(bt_res), .sreg_new(bt_sreg), .wr(bt_wr), .act(bt_act)
  );

  always_comb begin
    if (sh_act) begin
      nx_res = sh_res; nx_we = 1'b1; nx_sreg = sh_sreg;
    end else if (sw_act) begin
      nx_res = sh_res; nx_we = 1'b1; nx_sreg = sreg_in;
    end else if (bt_act) begin
      nx_res = bt_res; nx_we = bt_wr; nx_sreg = bt_sreg;
    end else begin
      nx_res = operand; nx_we = 1'b0; nx_sreg = sreg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      res_we   <= 1'b0;
      sreg_out <= '0;
    end else begin
      result   <= nx_res;
      res_we   <= nx_we;
      sreg_out <= nx_sreg;
    end
  end

  assert_swap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_SWAP) |-> (sreg_out == $past(sreg_in)));

  assert_right_keeps_h_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) inside {OP_LSR, OP_ROR, OP_ASR}) |-> (sreg_out[FL_H] == $past(sreg_in[FL_H])));

  assert_shift_vs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR}) |->
      ((sreg_out[FL_V] == (sreg_out[FL_N] ^ sreg_out[FL_C])) &&
       (sreg_out[FL_S] == (sreg_out[FL_N] ^ sreg_out[FL_V])) &&
       (sreg_out[FL_N] == result[W-1])));

  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) inside {OP_FSET, OP_FCLR}) |-> ($countones(sreg_out ^ $past(sreg_in)) <= 1));

  assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) inside {OP_NOP, OP_BST, OP_FSET, OP_FCLR}) |-> !res_we);

  assert_rol_carry_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_ROL) |-> (result[0] == $past(sreg_in[FL_C])));
endmodule

// File: tb/shbit_unit_bench.sv
module shbit_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] sreg_in = 8'd0;
  logic [7:0] result;
  logic       res_we;
  logic [7:0] sreg_out;

  int checks = 0;
  int errors = 0;
  logic [16:0] exp;

  always #2 clk = ~clk;

  shbit_unit u_shbit_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .bit_idx(bit_idx),
    .operand(operand), .sreg_in(sreg_in),
    .result(result), .res_we(res_we), .sreg_out(sreg_out)
  );

  // Returns {we, result[7:0], sreg[7:0]}; status bits I T H S V N Z C = 7..0
  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [2:0] ix, input logic [7:0] s);
    logic [7:0] r; logic [7:0] ns; logic we; logic c, n, v;
    r = a; ns = s; we = 1'b0;
    if (op >= 4'd1 && op <= 4'd5) begin
      we = 1'b1;
      case (op)
        4'd1: begin r = a << 1; c = a[7]; ns[5] = a[3]; end
        4'd2: begin r = a >> 1; c = a[0]; end
        4'd3: begin r = (a << 1) | {7'd0, s[0]}; c = a[7]; ns[5] = a[3]; end
        4'd4: begin r = (a >> 1) | {s[0], 7'd0}; c = a[0]; end
        default: begin r = $unsigned($signed(a) >>> 1); c = a[0]; end
      endcase
      n = r[7]; v = n ^ c;
      ns[0] = c; ns[1] = (r == 8'd0); ns[2] = n; ns[3] = v; ns[4] = n ^ v;
    end else if (op == 4'd6) begin
      r = {a[3:0], a[7:4]}; we = 1'b1;
    end else if (op == 4'd7) begin
      ns[6] = a[ix];
    end else if (op == 4'd8) begin
      r[ix] = s[6]; we = 1'b1;
    end else if (op == 4'd9) begin
      ns[ix] = 1'b1;
    end else if (op == 4'd10) begin
      ns[ix] = 1'b0;
    end
    return {we, r, ns};
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, expv);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [2:0] ix, input logic [7:0] s);
    @(negedge clk);
    op_sel = op; operand = a; bit_idx = ix; sreg_in = s;
    exp = model(op, a, ix, s);
    @(negedge clk);  // R11: one registered stage, visible after the next edge
    chk(tag(op), result, exp[15:8], "result");
    chk((op >= 4'd1 && op <= 4'd5) ? "R5" : tag(op), sreg_out, exp[7:0], "sreg");
    chk("R10", {7'd0, res_we}, {7'd0, exp[16]}, "res_we");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    op_sel = 4'd1; operand = 8'hFF; sreg_in = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", result, 8'h00, "reset result");
    chk("R11", sreg_out, 8'h00, "reset sreg");
    chk("R11", {7'd0, res_we}, 8'h00, "reset we");
    rst_n = 1'b1;
    // directed corners
    run(4'd1, 8'h80, 3'd0, 8'h00);  // R1 result zero, carry out
    run(4'd1, 8'h08, 3'd0, 8'h00);  // R1 half carry
    run(4'd2, 8'h01, 3'd0, 8'h20);  // R2 H kept
    run(4'd3, 8'h00, 3'd0, 8'h01);  // R3 carry in
    run(4'd4, 8'h01, 3'd0, 8'h01);  // R3 right rotate
    run(4'd5, 8'h81, 3'd0, 8'h20);  // R4 sign kept
    run(4'd5, 8'h01, 3'd0, 8'h00);  // R5 zero result
    run(4'd6, 8'hA5, 3'd0, 8'h5A);  // R6
    run(4'd7, 8'h10, 3'd4, 8'h00);  // R7
    run(4'd8, 8'h00, 3'd7, 8'h40);  // R8
    for (int i = 0; i < 8; i++) begin
      run(4'd9, 8'h00, 3'(i), 8'h00);   // R9 set each bit
      run(4'd10, 8'h00, 3'(i), 8'hFF);  // R9 clear each bit
    end
    run(4'd15, 8'h3C, 3'd2, 8'h99);  // R10 unused code
    run(4'd0, 8'hC3, 3'd1, 8'h66);   // R10 no-op
    for (int i = 0; i < 400; i++)
      run(4'($urandom_range(15)), 8'($urandom), 3'($urandom), 8'($urandom));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule